// File: doc/BRIEF.md
# Variable-Width Chunked SPI Master

This block is a serial peripheral interface master. The host queues transmit words into a small FIFO. Each word carries its own bit count, so every queued word becomes one chunk of 1 to 24 bits on the wire. Bits shifted in on the serial input are collected into a receive FIFO. The host drains that FIFO through the same data address it uses for writes.

The host writes to one of two data addresses. That choice decides whether the active-low chip select is released one SCLK period after the chunk ends or stays asserted, so the next chunk continues the same frame. After every chunk the clock stays at its idle level for two full SCLK periods before any further chunk can begin. Clock polarity, the output and input clock phases and the shift direction of each side are set in two control words. The SCLK rate comes from a 12-bit divider.

The host port is a flat register bus. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational, and a read of a data address with `reg_rd` high pops the receive FIFO on that edge. Two level-type interrupt outputs signal an empty transmit FIFO and an idle engine.

Top module: `vw_spi_master`

## Requirements
- R1: One SCLK half period lasts speed+1 system clocks, where speed is control word 0 bits 31:20. A chunk of n bits produces exactly 2n SCLK edges. Whenever the engine is not busy, SCLK rests at the level of CPOL (control word 0 bit 7).
- R2: In a transmit word, bits 31:24 give the bit count and bits 23:0 the payload. With MSB-first out set (control word 0 bit 6), the payload leaves from bit 23 downward. With it clear, the payload leaves from bit 0 upward.
- R3: A bit count field of 0, or of any value above 24, is treated as 24.
- R4: Received bits are right-aligned in bits 23:0 of the receive word, and bits 31:24 read as zero. With MSB-first in set (control word 1 bit 1), each new bit shifts in at bit 0. With it clear, the k-th received bit lands at bit k.
- R5: With output phase (control word 0 bit 8) clear, MOSI changes on trailing SCLK edges. With it set, MOSI changes on leading edges. With input phase (control word 0 bit 10) clear, MISO is sampled on leading edges. With it set, MISO is sampled on trailing edges.
- R6: Chip select is active low and falls when a chunk starts. A chunk written to register index 3 releases it one SCLK period after its last edge. A chunk written to register index 4 leaves it asserted into the next chunk.
- R7: After each chunk, SCLK stays idle for two SCLK periods before the next chunk starts.
- R8: Status word (index 2) layout: bits 31:24 hold the TX level, bits 23:16 the RX level, bit 10 TX full, bit 9 TX empty, bit 8 RX full, bit 7 RX empty, bit 6 busy, and bits 5:0 the bits still to shift in the current chunk. All other bits are zero.
- R9: Each FIFO holds FIFO_DEPTH entries (4 by default). A data write while TX is full is dropped. A chunk that completes while RX is full is dropped. A data read while RX is empty returns zero.
- R10: Writing control word 0 with bit 9 set and enable (bit 11) clear empties both FIFOs.
- R11: irq_txe is high when control word 1 bit 6 is set and TX is empty. irq_idle is high when control word 1 bit 7 is set, TX is empty and the engine is not busy.
- R12: Index 0 is control word 0 and index 1 is control word 1. Both read back as written, and reset clears them to zero.
- R13: While enable is clear, no chunk starts, SCLK does not toggle and chip select stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on data addresses) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_txe | output | 1 | Transmit-empty interrupt |
| irq_idle | output | 1 | Idle interrupt |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench loops MOSI back to MISO. It rebuilds the outbound bit stream from the SCLK edges that the phase setting defines, so each shift order and phase combination is checked both on the wire and in the received word. A design that swapped the phase meaning or the alignment would show a shifted or mirrored pattern. The chip-select low time is counted in system clocks for a single chunk, for two held chunks and for two released chunks. An engine that dropped the idle gap, released chip select too early or kept it across a released chunk would show a different count. Zero and oversized bit counts, both FIFOs full, reads from an empty RX FIFO, the clear command and the interrupt conditions each get a directed test. A design that wraps a full FIFO, clamps wrongly or misses a flush gives wrong levels or data.

// File: rtl/vwspi_pkg.sv
// Package: shared constants, transmit entry type and engine states for the
// variable-width SPI master. Assumes chunks never exceed 24 bits.
package vwspi_pkg;
    localparam int unsigned CHUNK_MAX = 24;
    localparam int unsigned LEN_W     = 5;
    localparam int unsigned DIV_W     = 12;

    // register indices
    localparam logic [2:0] A_CTRL0  = 3'd0;
    localparam logic [2:0] A_CTRL1  = 3'd1;
    localparam logic [2:0] A_STATUS = 3'd2;
    localparam logic [2:0] A_DATA   = 3'd3;
    localparam logic [2:0] A_HOLD   = 3'd4;

    // control word bit positions
    localparam int unsigned C0_PHASE_IN  = 10;
    localparam int unsigned C0_ENABLE    = 11;
    localparam int unsigned C0_CLEAR     = 9;
    localparam int unsigned C0_PHASE_OUT = 8;
    localparam int unsigned C0_CPOL      = 7;
    localparam int unsigned C0_MSB_OUT   = 6;
    localparam int unsigned C1_IE_IDLE   = 7;
    localparam int unsigned C1_IE_TXE    = 6;
    localparam int unsigned C1_MSB_IN    = 1;

    typedef struct packed {
        logic                 hold;
        logic [LEN_W-1:0]     len;
        logic [CHUNK_MAX-1:0] data;
    } tx_entry_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} eng_state_t;

    // Map a raw 8-bit count field onto 1..24.
    function automatic logic [LEN_W-1:0] clamp_len(input logic [7:0] f);
        if (f == 8'd0 || f > 8'(CHUNK_MAX)) return LEN_W'(CHUNK_MAX);
        return f[LEN_W-1:0];
    endfunction
endpackage

// File: rtl/vwspi_fifo.sv
// Synchronous FIFO with flush. Push when full and pop when empty are ignored.
// Assumes DEPTH >= 2. dout shows the oldest entry whenever empty is low.
module vwspi_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [AW:0]   level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == (AW+1)'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp];

    // Storage write, no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            level <= level + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
        end
    end
endmodule

// File: rtl/vwspi_engine.sv
// Shift engine: takes one transmit entry, clocks out its bits, samples MISO,
// then holds SCLK idle for two periods before the next chunk. It assumes the
// configuration inputs stay stable while a chunk is in flight.
module vwspi_engine
    import vwspi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [DIV_W-1:0]     speed,
    input  logic                 cpol,
    input  logic                 phase_out,
    input  logic                 phase_in,
    input  logic                 msb_out,
    input  logic                 msb_in,
    input  logic                 tx_valid,
    input  tx_entry_t            tx_entry,
    input  logic                 miso,
    output logic                 tx_pop,
    output logic                 rx_push,
    output logic [CHUNK_MAX-1:0] rx_word,
    output logic                 sclk,
    output logic                 mosi,
    output logic                 cs_n,
    output logic                 busy,
    output logic                 shifting,
    output logic [5:0]           bits_left
);
    localparam int unsigned HALF_W = LEN_W + 1;

    eng_state_t           state;
    logic [DIV_W-1:0]     div_cnt;
    logic [HALF_W-1:0]    half;
    logic [1:0]           gap;
    tx_entry_t            cur;
    logic                 phase, push_q;
    logic [CHUNK_MAX-1:0] rx_sh;
    logic                 tick, start, last_half, sample;
    logic [LEN_W-1:0]     idx_out, pos_out, idx_in;

    assign tick      = (div_cnt == speed);
    assign start     = (state == ST_IDLE) && enable && tx_valid;
    assign last_half = (half == HALF_W'({cur.len, 1'b0}) - HALF_W'(1));
    assign sample    = tick && (state == ST_SHIFT) && (half[0] == phase_in);
    assign idx_in    = half[HALF_W-1:1];
    assign idx_out   = (phase_out && half != '0) ? LEN_W'((half - HALF_W'(1)) >> 1)
                                                 : half[HALF_W-1:1];
    assign pos_out   = msb_out ? LEN_W'(CHUNK_MAX-1) - idx_out : idx_out;

    assign tx_pop    = start;
    assign rx_push   = push_q;
    assign rx_word   = rx_sh;
    assign sclk      = cpol ^ phase;
    assign busy      = (state != ST_IDLE);
    assign shifting  = (state == ST_SHIFT);
    assign mosi      = busy ? cur.data[pos_out] : 1'b0;
    assign bits_left = shifting ? 6'(cur.len) - 6'(idx_in) : 6'd0;

    // Half-period divider, restarted while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE || tick) div_cnt <= '0;
        else                                    div_cnt <= div_cnt + 1'b1;
    end

    // Chunk sequencing: start, half-period stepping, idle gap, CS release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            half   <= '0;
            gap    <= '0;
            cur    <= '0;
            phase  <= 1'b0;
            cs_n   <= 1'b1;
            push_q <= 1'b0;
        end else begin
            push_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur   <= tx_entry;
                        half  <= '0;
                        phase <= 1'b0;
                        cs_n  <= 1'b0;
                        state <= ST_SHIFT;
                    end else if (!enable) begin
                        cs_n <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        phase <= ~phase;
                        if (last_half) begin
                            state  <= ST_GAP;
                            gap    <= '0;
                            push_q <= 1'b1;
                        end else begin
                            half <= half + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        gap <= gap + 1'b1;
                        if (gap == 2'd1 && !cur.hold) cs_n <= 1'b1;
                        if (gap == 2'd3) state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Receive shifter: right-aligned capture in either bit order.
    always_ff @(posedge clk) begin
        if (!rst_n || start) rx_sh <= '0;
        else if (sample) begin
            if (msb_in) rx_sh <= {rx_sh[CHUNK_MAX-2:0], miso};
            else        rx_sh[idx_in] <= miso;
        end
    end
endmodule

// File: rtl/vw_spi_master.sv
// Top: register file, TX/RX FIFOs and the shift engine. Data writes to
// index 3 release CS after the chunk; index 4 keeps it asserted. Reads of
// either data index pop the RX FIFO. Assumes one register access per cycle.
module vw_spi_master
    import vwspi_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4,
    localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_txe,
    output logic        irq_idle,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);
    logic [31:0]          ctrl0_q, ctrl1_q;
    logic                 data_addr, flush_req, tx_push, rx_pop;
    tx_entry_t            tx_in, tx_head;
    logic                 tx_pop, tx_full, tx_empty;
    logic                 rx_push, rx_full, rx_empty;
    logic [LVL_W-1:0]     tx_level, rx_level;
    logic [CHUNK_MAX-1:0] rx_word, rx_head;
    logic                 busy, shifting;
    logic [5:0]           bits_left;
    logic [31:0]          status;

    assign data_addr = (reg_addr == A_DATA) || (reg_addr == A_HOLD);
    assign flush_req = reg_wr && reg_addr == A_CTRL0 &&
                       reg_wdata[C0_CLEAR] && !reg_wdata[C0_ENABLE];
    assign tx_push   = reg_wr && data_addr;
    assign rx_pop    = reg_rd && data_addr;
    assign tx_in     = '{hold: (reg_addr == A_HOLD),
                         len:  clamp_len(reg_wdata[31:24]),
                         data: reg_wdata[CHUNK_MAX-1:0]};

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl0_q <= '0;
            ctrl1_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL0) ctrl0_q <= reg_wdata;
            if (reg_addr == A_CTRL1) ctrl1_q <= reg_wdata;
        end
    end

    vwspi_fifo #(.W($bits(tx_entry_t)), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_req),
        .push(tx_push), .din(tx_in), .pop(tx_pop), .dout(tx_head),
        .level(tx_level), .full(tx_full), .empty(tx_empty));

    vwspi_fifo #(.W(CHUNK_MAX), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_req),
        .push(rx_push), .din(rx_word), .pop(rx_pop), .dout(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty));

    vwspi_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .enable(ctrl0_q[C0_ENABLE]), .speed(ctrl0_q[31:20]),
        .cpol(ctrl0_q[C0_CPOL]), .phase_out(ctrl0_q[C0_PHASE_OUT]),
        .phase_in(ctrl0_q[C0_PHASE_IN]), .msb_out(ctrl0_q[C0_MSB_OUT]),
        .msb_in(ctrl1_q[C1_MSB_IN]),
        .tx_valid(!tx_empty), .tx_entry(tx_head), .miso(spi_miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .busy(busy), .shifting(shifting), .bits_left(bits_left));

    assign status = {8'(tx_level), 8'(rx_level), 5'b0, tx_full, tx_empty,
                     rx_full, rx_empty, busy, bits_left};

    // Read-data selection by register index.
    always_comb begin
        unique case (reg_addr)
            A_CTRL0:         reg_rdata = ctrl0_q;
            A_CTRL1:         reg_rdata = ctrl1_q;
            A_STATUS:        reg_rdata = status;
            A_DATA, A_HOLD:  reg_rdata = rx_empty ? 32'd0 : 32'(rx_head);
            default:         reg_rdata = 32'd0;
        endcase
    end

    assign irq_txe  = ctrl1_q[C1_IE_TXE] && tx_empty;
    assign irq_idle = ctrl1_q[C1_IE_IDLE] && tx_empty && !busy;
endmodule

// File: rtl/vwspi_checker.sv
// Checker: temporal properties of the SPI master, attached by bind.
module vwspi_checker #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpol,
    input logic             enable,
    input logic             busy,
    input logic             shifting,
    input logic             sclk,
    input logic             cs_n,
    input logic [5:0]       bits_left,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             clr,
    input logic             irq_idle
);
    p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == cpol);

    p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shifting |-> (bits_left != 6'd0 && bits_left <= 6'd24));

    p_cs_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shifting |-> !cs_n);

    p_cs_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) && $past(enable)) |-> $past(busy));

    p_gap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !shifting) |-> sclk == cpol);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> tx_level == '0);

    p_idle_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idle |-> (!shifting && sclk == cpol));
endmodule

bind vw_spi_master vwspi_checker #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpol(ctrl0_q[7]), .enable(ctrl0_q[11]),
    .busy(busy), .shifting(shifting), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .bits_left(bits_left), .tx_level(tx_level), .rx_level(rx_level),
    .clr(flush_req), .irq_idle(irq_idle));

// File: tb/vw_spi_master_test.sv
// Bench: MOSI looped to MISO, vector table of chunk modes, then directed tests.
module vw_spi_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_txe, irq_idle, sclk, mosi, cs_n;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;

    vw_spi_master uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_txe(irq_txe), .irq_idle(irq_idle), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(mosi), .spi_cs_n(cs_n));

    typedef struct packed {
        logic        cpol;
        logic        cpha;
        logic        mo;
        logic        mi;
        logic [7:0]  lenf;
        logic [23:0] data;
        logic [23:0] exp;
        logic [5:0]  n;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'd8,    24'hA50000, 24'h0000A5, 6'd8},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'd24,   24'h123456, 24'h123456, 6'd24},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'd0,    24'hC3C3C3, 24'hC3C3C3, 6'd24},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h30,   24'h0F0F0F, 24'h0F0F0F, 6'd24},
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'd12,   24'hABC000, 24'h000ABC, 6'd12},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd8,    24'h00005A, 24'h00005A, 6'd8},
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'd8,    24'hC10000, 24'h000083, 6'd8},
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'd16,   24'hBEEF00, 24'h00BEEF, 6'd16},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'd4,    24'h900000, 24'h000009, 6'd4},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd8,    24'h000001, 24'h000080, 6'd8}
    };

    // Wire monitor: CS-low time, SCLK edges, MOSI at the phase-defined edge.
    logic        cur_cpol = 1'b0, cur_cpha = 1'b0, prev_sclk = 1'b0;
    int          cs_low_total = 0, edge_total = 0;
    logic [31:0] mon_sh = '0;
    always @(negedge clk) begin
        prev_sclk <= sclk;
        if (rst_n && !cs_n) cs_low_total <= cs_low_total + 1;
        if (rst_n && sclk != prev_sclk) begin
            edge_total <= edge_total + 1;
            if ((sclk != cur_cpol) != cur_cpha) mon_sh <= {mon_sh[30:0], mosi};
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, input logic pop, output logic [31:0] d);
        reg_addr = a; reg_rd = pop;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        repeat (2) @(negedge clk);
        read_reg(3'd2, 1'b0, st);
        while (st[6] || !st[9]) read_reg(3'd2, 1'b0, st);
    endtask

    // Expected outbound bit sequence, first bit ends up most significant.
    function automatic logic [31:0] exp_out(input logic [23:0] d, input int n, input logic mo);
        logic [31:0] r = '0;
        for (int k = 0; k < n; k++) r = {r[30:0], mo ? d[23-k] : d[k]};
        return r;
    endfunction

    initial begin
        logic [31:0] rd;
        int e0, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        read_reg(3'd2, 1'b0, rd);
        check("R8 reset status", rd, 32'h0000_0280);
        read_reg(3'd0, 1'b0, rd);
        check("R12 reset ctrl0", rd, 32'h0);
        check("R6 reset cs_n", {31'b0, cs_n}, 32'h1);
        check("R1 reset sclk", {31'b0, sclk}, 32'h0);
        check("R11 reset irqs", {30'b0, irq_txe, irq_idle}, 32'h0);

        // table of chunk modes at speed 0
        for (int i = 0; i < NV; i++) begin
            write_reg(3'd1, {30'b0, VEC[i].mi, 1'b0});
            write_reg(3'd0, (32'h1 << 11) | ({31'b0, VEC[i].cpha} << 10) |
                            ({31'b0, VEC[i].cpha} << 8) | ({31'b0, VEC[i].cpol} << 7) |
                            ({31'b0, VEC[i].mo} << 6));
            cur_cpol = VEC[i].cpol; cur_cpha = VEC[i].cpha;
            repeat (2) @(negedge clk);
            e0 = edge_total; c0 = cs_low_total;
            write_reg(3'd3, {VEC[i].lenf, VEC[i].data});
            wait_idle();
            check("R1 edge count", 32'(edge_total - e0), 32'(2 * VEC[i].n));
            check("R6 cs low cycles", 32'(cs_low_total - c0), 32'(2 * VEC[i].n + 2));
            check("R2 R3 R5 mosi stream", mon_sh & ((32'h1 << VEC[i].n) - 1),
                  exp_out(VEC[i].data, int'(VEC[i].n), VEC[i].mo));
            read_reg(3'd3, 1'b1, rd);
            check("R4 rx word", rd, {8'b0, VEC[i].exp});
            check("R1 sclk idle level", {31'b0, sclk}, {31'b0, VEC[i].cpol});
        end

        // divider: speed 2 gives 3-clock half periods
        write_reg(3'd1, 32'h2);
        write_reg(3'd0, (32'd2 << 20) | (32'h1 << 11) | (32'h1 << 6));
        cur_cpol = 1'b0; cur_cpha = 1'b0;
        repeat (2) @(negedge clk);
        e0 = edge_total; c0 = cs_low_total;
        write_reg(3'd3, {8'd8, 24'h5A0000});
        read_reg(3'd2, 1'b0, rd);
        read_reg(3'd2, 1'b0, rd);
        check("R8 busy status with bits left", rd, 32'h0000_02C8);
        wait_idle();
        check("R1 divided cs low", 32'(cs_low_total - c0), 32'd54);
        check("R1 divided edges", 32'(edge_total - e0), 32'd16);
        read_reg(3'd3, 1'b1, rd);
        check("R4 divided rx", rd, 32'h5A);

        // held pair: CS stays low across the gap (R6, R7)
        write_reg(3'd0, (32'h1 << 11) | (32'h1 << 6));
        repeat (2) @(negedge clk);
        c0 = cs_low_total;
        write_reg(3'd4, {8'd8, 24'h110000});
        write_reg(3'd3, {8'd8, 24'h220000});
        wait_idle();
        check("R6 R7 held pair cs low", 32'(cs_low_total - c0), 32'd39);
        read_reg(3'd3, 1'b1, rd);
        check("R4 held first", rd, 32'h11);
        read_reg(3'd4, 1'b1, rd);
        check("R4 held second", rd, 32'h22);

        // released pair: CS returns high between chunks
        c0 = cs_low_total;
        write_reg(3'd3, {8'd8, 24'h330000});
        write_reg(3'd3, {8'd8, 24'h440000});
        wait_idle();
        check("R6 released pair cs low", 32'(cs_low_total - c0), 32'd36);
        read_reg(3'd3, 1'b1, rd);
        read_reg(3'd3, 1'b1, rd);
        check("R4 released second", rd, 32'h44);

        // disabled: TX fills, overflow dropped, nothing on the wire
        write_reg(3'd0, 32'h0);
        write_reg(3'd1, 32'hC2);
        e0 = edge_total;
        for (int k = 0; k < 5; k++) write_reg(3'd3, {8'd4, 4'(k + 1), 20'h0});
        repeat (4) @(negedge clk);
        read_reg(3'd2, 1'b0, rd);
        check("R9 tx full status", rd, 32'h0400_0480);
        check("R13 no edges while disabled", 32'(edge_total - e0), 32'd0);
        check("R13 cs high while disabled", {31'b0, cs_n}, 32'h1);
        check("R11 irqs with tx pending", {30'b0, irq_txe, irq_idle}, 32'h0);
        write_reg(3'd0, 32'h200);
        read_reg(3'd2, 1'b0, rd);
        check("R10 clear empties fifos", rd, 32'h0000_0280);
        check("R11 irqs when empty", {30'b0, irq_txe, irq_idle}, 32'h3);
        read_reg(3'd1, 1'b0, rd);
        check("R12 ctrl1 readback", rd, 32'hC2);
        read_reg(3'd3, 1'b1, rd);
        check("R9 empty read zero", rd, 32'h0);

        // RX overflow: fifth chunk dropped
        write_reg(3'd0, (32'h1 << 11) | (32'h1 << 6));
        for (int k = 0; k < 5; k++) begin
            write_reg(3'd3, {8'd4, 4'(k + 1), 20'h0});
            wait_idle();
        end
        read_reg(3'd2, 1'b0, rd);
        check("R9 rx full status", rd, 32'h0004_0300);
        for (int k = 0; k < 4; k++) begin
            read_reg(3'd3, 1'b1, rd);
            check("R9 rx order", rd, 32'(k + 1));
        end
        read_reg(3'd3, 1'b1, rd);
        check("R9 fifth dropped", rd, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule